// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache placed between a processor load/store port and a word-wide main-memory port. Each byte address is cut into a tag, a line index and an offset; every line keeps one block of words together with a tag, a valid flag and a dirty flag. Lookups that hit are served in the cycle they are presented. Lookups that miss stall the processor while the controller moves blocks to and from memory.

Two mode inputs choose the store behaviour at run time. One selects write-back or write-through, the other selects write-allocate or no-write-allocate. In write-back mode modified lines are marked dirty and are copied to memory only when they are evicted or when a flush request walks the whole cache. Two saturating counters record hits and misses, one event per processor request.

Top module: `dm_cache`

## Requirements
- R1: The byte address splits into tag, index and word fields: with the defaults, tag = addr[31:14], index = addr[13:4] and word = addr[3:2]. In general, index = addr[IDX_W+3:4], word = addr[3:2] for 4-word blocks, and tag = the bits above the index. Bits [1:0] have no effect on any access.
- R2: After reset every line is invalid, cpu_ready is 1, mem_req is 0 and both counters are 0. The first load to any line misses, even when the stored tag equals the address tag.
- R3: A load whose line is valid and whose tag matches is a hit. It is accepted in its first cycle with cpu_ready = 1, cpu_rdata holding the word chosen by the word field, and no memory traffic.
- R4: A load to a valid line holding a different tag replaces the block and tag with the block fetched from memory, and returns the requested word from the new data.
- R5: A fill issues 4 word reads at {tag, index, n, 2'b00} for n = 0,1,2,3 in that order. cpu_ready stays 0 from the cycle the miss is seen until the fill or write sequence ends.
- R6: With wb_mode = 1 (write-back), a store hit writes only the cached word, with no memory access, and marks the line dirty. A later load returns the stored word.
- R7: Evicting a dirty line first writes its 4 words to {old tag, index, n, 2'b00}, n ascending, and only then starts the fill. Evicting a clean line causes no memory write. Allocation leaves the line clean.
- R8: With wb_mode = 0 (write-through), every store performs exactly one memory write of cpu_wdata at the word-aligned address. On a hit it also updates the cached word and leaves the line clean.
- R9: A store miss with wr_alloc = 1 first fills the block and then updates the word. No memory write occurs in write-back mode.
- R10: A store miss with wr_alloc = 0 performs one memory write and no read, and leaves the cache unchanged, so a later load to that line misses.
- R11: A flush_req accepted while idle visits every index in ascending order and writes back each dirty line, clearing its dirty flag. flush_done is then high for exactly one cycle. A second flush writes nothing.
- R12: hit_count and miss_count each increase by one per request on its first lookup and saturate at all ones.
- R13: While mem_req is 1 and mem_ready is 0, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| wr_alloc | input | 1 | 1 = allocate on store miss, 0 = no allocate |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request accepted when cpu_req and cpu_ready are both 1 |
| cpu_rdata | output | DATA_W | Load data, valid in the accepting cycle |
| flush_req | input | 1 | Start a write-back sweep of all lines |
| flush_done | output | 1 | One-cycle pulse when the sweep ends |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | DATA_W | Memory read data |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bench builds the cache with IDX_W = 4 and CNT_W = 3, and keeps the default 32-bit address and 4-word blocks. Sixteen lines make conflicting addresses only 0x100 apart. The flush sweep becomes short enough to check its ascending write order in full, and both counters reach saturation within a few dozen requests. A small memory model with two wait states exercises the stall and the hold of the memory request.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_EVICT,
    S_FILL,
    S_WRITE,
    S_FSCAN,
    S_FWR
  } ctrl_state_e;
endpackage

// File: rtl/dmc_sat_cnt.sv
module dmc_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != MAXV);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (count == MAXV));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             inst_en,
  input  logic             set_dirty_en,
  input  logic             clr_dirty_en,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel, upd, v_d, d_d;
    always_comb begin
      sel = (idx == IDX_W'(i));
      upd = sel && (inst_en || set_dirty_en || clr_dirty_en);
      v_d = valid_q[i] || inst_en;
      d_d = set_dirty_en ? 1'b1 : ((inst_en || clr_dirty_en) ? 1'b0 : dirty_q[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (upd) begin
        valid_q[i] <= v_d;
        dirty_q[i] <= d_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[idx] <= wr_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  // R7
  alloc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |=> ((idx != $past(idx)) || (rd_valid && !rd_dirty)));
  // R6
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> rd_valid);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << WORD_W;

  logic [DATA_W-1:0] mem_q [LINES][WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx][wr_word] <= wr_data;
  end

  assign rd_data = mem_q[idx][rd_word];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int WORD_W = 2,
  parameter int BYTE_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wb_mode,
  input  logic                             wr_alloc,
  input  logic                             cpu_req,
  input  logic                             cpu_we,
  input  logic [ADDR_W-1:0]                cpu_addr,
  input  logic [DATA_W-1:0]                cpu_wdata,
  output logic                             cpu_ready,
  input  logic                             flush_req,
  output logic                             flush_done,
  output logic                             mem_req,
  output logic                             mem_we,
  output logic [ADDR_W-1:0]                mem_addr,
  output logic [DATA_W-1:0]                mem_wdata,
  input  logic                             mem_ready,
  input  logic [DATA_W-1:0]                mem_rdata,
  output logic [IDX_W-1:0]                 line_idx,
  input  logic                             rd_valid,
  input  logic                             rd_dirty,
  input  logic [ADDR_W-IDX_W-WORD_W-BYTE_W-1:0] rd_tag,
  output logic                             inst_en,
  output logic                             set_dirty_en,
  output logic                             clr_dirty_en,
  output logic [WORD_W-1:0]                rd_word,
  input  logic [DATA_W-1:0]                rd_data,
  output logic                             dwr_en,
  output logic [WORD_W-1:0]                dwr_word,
  output logic [DATA_W-1:0]                dwr_data,
  output logic                             hit_evt,
  output logic                             miss_evt
);
  localparam int OFF_W = WORD_W + BYTE_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  ctrl_state_e       state_q, state_d;
  logic [WORD_W-1:0] wcnt_q, wcnt_d;
  logic [IDX_W-1:0]  fidx_q, fidx_d;
  logic              retry_q, retry_d;
  logic              bypass_q, bypass_d;
  logic              done_q, done_d;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WORD_W-1:0] a_word;
  logic [BYTE_W-1:0] byte_sel_unused;
  logic              flush_mode, hit, victim_dirty, last_word, last_idx;

  always_comb begin
    a_tag           = cpu_addr[ADDR_W-1 -: TAG_W];
    a_idx           = cpu_addr[OFF_W +: IDX_W];
    a_word          = cpu_addr[BYTE_W +: WORD_W];
    byte_sel_unused = cpu_addr[BYTE_W-1:0];
    flush_mode      = (state_q == S_FSCAN) || (state_q == S_FWR);
    line_idx        = flush_mode ? fidx_q : a_idx;
    hit             = rd_valid && (rd_tag == a_tag);
    victim_dirty    = rd_valid && rd_dirty;
    last_word       = (wcnt_q == '1);
    last_idx        = (fidx_q == '1);
  end

  // next-state and output decode
  always_comb begin
    state_d      = state_q;
    wcnt_d       = wcnt_q;
    fidx_d       = fidx_q;
    retry_d      = retry_q;
    bypass_d     = bypass_q;
    done_d       = 1'b0;
    cpu_ready    = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    inst_en      = 1'b0;
    set_dirty_en = 1'b0;
    clr_dirty_en = 1'b0;
    rd_word      = a_word;
    dwr_en       = 1'b0;
    dwr_word     = a_word;
    dwr_data     = cpu_wdata;
    hit_evt      = 1'b0;
    miss_evt     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cpu_req) begin
          if (!retry_q) begin
            hit_evt  = hit;
            miss_evt = !hit;
          end
          if (bypass_q || (hit && (!cpu_we || wb_mode))) begin
            cpu_ready = 1'b1;
            retry_d   = 1'b0;
            bypass_d  = 1'b0;
            if (cpu_we && hit) begin
              dwr_en       = 1'b1;
              set_dirty_en = wb_mode;
            end
          end else if (hit || (cpu_we && !wr_alloc)) begin
            retry_d = 1'b1;
            state_d = S_WRITE;
          end else begin
            retry_d = 1'b1;
            wcnt_d  = '0;
            state_d = victim_dirty ? S_EVICT : S_FILL;
          end
        end else begin
          cpu_ready = 1'b1;
          if (flush_req) begin
            fidx_d  = '0;
            state_d = S_FSCAN;
          end
        end
      end
      S_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        rd_word   = wcnt_q;
        mem_addr  = {rd_tag, a_idx, wcnt_q, {BYTE_W{1'b0}}};
        mem_wdata = rd_data;
        if (mem_ready) begin
          wcnt_d = wcnt_q + 1'b1;
          if (last_word) state_d = S_FILL;
        end
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {a_tag, a_idx, wcnt_q, {BYTE_W{1'b0}}};
        if (mem_ready) begin
          dwr_en   = 1'b1;
          dwr_word = wcnt_q;
          dwr_data = mem_rdata;
          wcnt_d   = wcnt_q + 1'b1;
          if (last_word) begin
            inst_en = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
      S_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        mem_wdata = cpu_wdata;
        if (mem_ready) begin
          bypass_d = 1'b1;
          state_d  = S_IDLE;
        end
      end
      S_FSCAN: begin
        if (victim_dirty) begin
          wcnt_d  = '0;
          state_d = S_FWR;
        end else if (last_idx) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          fidx_d = fidx_q + 1'b1;
        end
      end
      S_FWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        rd_word   = wcnt_q;
        mem_addr  = {rd_tag, fidx_q, wcnt_q, {BYTE_W{1'b0}}};
        mem_wdata = rd_data;
        if (mem_ready) begin
          wcnt_d = wcnt_q + 1'b1;
          if (last_word) begin
            clr_dirty_en = 1'b1;
            if (last_idx) begin
              done_d  = 1'b1;
              state_d = S_IDLE;
            end else begin
              fidx_d  = fidx_q + 1'b1;
              state_d = S_FSCAN;
            end
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wcnt_q   <= '0;
      fidx_q   <= '0;
      retry_q  <= 1'b0;
      bypass_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      wcnt_q   <= wcnt_d;
      fidx_q   <= fidx_d;
      retry_q  <= retry_d;
      bypass_q <= bypass_d;
      done_q   <= done_d;
    end
  end

  assign flush_done = done_q;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata)));
  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              wr_alloc,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int WORD_W = $clog2(WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - BYTE_W;

  logic [IDX_W-1:0]  line_idx;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic              inst_en, set_dirty_en, clr_dirty_en;
  logic [WORD_W-1:0] rd_word, dwr_word;
  logic [DATA_W-1:0] rd_data, dwr_data;
  logic              dwr_en, hit_evt, miss_evt;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .wr_alloc(wr_alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .line_idx(line_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .inst_en(inst_en), .set_dirty_en(set_dirty_en), .clr_dirty_en(clr_dirty_en),
    .rd_word(rd_word), .rd_data(rd_data),
    .dwr_en(dwr_en), .dwr_word(dwr_word), .dwr_data(dwr_data),
    .hit_evt(hit_evt), .miss_evt(miss_evt)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .idx(line_idx),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .inst_en(inst_en), .set_dirty_en(set_dirty_en), .clr_dirty_en(clr_dirty_en),
    .wr_tag(cpu_addr[ADDR_W-1 -: TAG_W])
  );

  dmc_data_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .idx(line_idx), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(dwr_en), .wr_word(dwr_word), .wr_data(dwr_data)
  );

  dmc_sat_cnt #(.CNT_W(CNT_W)) hit_cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(hit_evt), .count(hit_count)
  );

  dmc_sat_cnt #(.CNT_W(CNT_W)) miss_cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(miss_evt), .count(miss_count)
  );

  assign cpu_rdata = rd_data;
endmodule

// File: tb/dm_cache_tb_top.sv
`timescale 1ns/1ps
module dm_cache_tb_top;
  localparam int IDX_W = 4;
  localparam int CNT_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b1, wr_alloc = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        flush_req = 1'b0, flush_done;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [CNT_W-1:0] hit_count, miss_count;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dm_cache #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .wr_alloc(wr_alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // memory model with two wait states and an access log
  logic [31:0] bmem [1024];
  logic        ev_we   [64];
  logic [31:0] ev_addr [64];
  logic [31:0] ev_data [64];
  int          ev_n = 0;
  int          wt = 0;
  int          done_cnt = 0;
  int          hold_viol = 0;
  logic        pend_q = 1'b0;
  logic [31:0] pend_addr = '0;

  initial for (int i = 0; i < 1024; i++) bmem[i] = 32'hC000_0000 | (i << 2);

  always @(posedge clk) begin
    if (pend_q && (!mem_req || mem_addr != pend_addr)) hold_viol++;
    pend_q    = mem_req && !mem_ready;
    pend_addr = mem_addr;
    if (flush_done) done_cnt++;
    if (mem_req && mem_ready) begin
      if (ev_n < 64) begin
        ev_we[ev_n]   = mem_we;
        ev_addr[ev_n] = mem_addr;
        ev_data[ev_n] = mem_we ? mem_wdata : mem_rdata;
      end
      ev_n++;
      if (mem_we) bmem[mem_addr[11:2]] = mem_wdata;
      mem_ready <= 1'b0;
      wt = 0;
    end else if (mem_req) begin
      if (wt == 2) begin
        mem_ready <= 1'b1;
        mem_rdata <= bmem[mem_addr[11:2]];
      end else wt++;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic check_ev(input string rq, input int i, input logic we,
                          input logic [31:0] a, input logic [31:0] d);
    check(rq, {31'b0, ev_we[i]}, {31'b0, we});
    check(rq, ev_addr[i], a);
    if (we) check(rq, ev_data[i], d);
  endtask

  function automatic int n_writes();
    int c = 0;
    for (int i = 0; i < ev_n && i < 64; i++) if (ev_we[i]) c++;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_req = 1'b0; flush_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_log();
    ev_n = 0;
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stall);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stall = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1; stall++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic run_flush();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    @(negedge clk);
  endtask

  logic [31:0] rd;
  int          st;
  int          dc;

  task automatic t_reset();
    check("R2 ready", {31'b0, cpu_ready}, 32'd1);
    check("R2 mem_req", {31'b0, mem_req}, 32'd0);
    check("R2 hits", 32'(hit_count), 32'd0);
    check("R2 misses", 32'(miss_count), 32'd0);
    check("R2 done", {31'b0, flush_done}, 32'd0);
  endtask

  task automatic t_cold_fill();
    clear_log();
    cpu_op(1'b0, 32'h014, '0, rd, st);
    check("R5 stall", {31'b0, st > 0}, 32'd1);
    check("R4 data", rd, 32'hC000_0014);
    check("R5 reads", ev_n, 4);
    for (int i = 0; i < 4; i++) check_ev("R5 fill order", i, 1'b0, 32'h010 + 4 * i, '0);
    check("R12 miss", 32'(miss_count), 32'd1);
  endtask

  task automatic t_hit_offset();
    clear_log();
    cpu_op(1'b0, 32'h01C, '0, rd, st);
    check("R3 stall", st, 0);
    check("R3 data", rd, 32'hC000_001C);
    cpu_op(1'b0, 32'h01F, '0, rd, st);
    check("R1 low bits", rd, 32'hC000_001C);
    check("R3 no traffic", ev_n, 0);
    check("R12 hits", 32'(hit_count), 32'd2);
    check("R12 misses", 32'(miss_count), 32'd1);
  endtask

  task automatic t_conflict();
    clear_log();
    cpu_op(1'b0, 32'h114, '0, rd, st);
    check("R4 new data", rd, 32'hC000_0114);
    check("R4 reads", ev_n, 4);
    check("R7 clean no write", n_writes(), 0);
    cpu_op(1'b0, 32'h014, '0, rd, st);
    check("R4 old tag misses", {31'b0, st > 0}, 32'd1);
    check("R4 data", rd, 32'hC000_0014);
  endtask

  task automatic t_wb_store_hit();
    wb_mode = 1'b1; wr_alloc = 1'b1;
    cpu_op(1'b0, 32'h034, '0, rd, st);
    clear_log();
    cpu_op(1'b1, 32'h038, 32'hDEAD_0001, rd, st);
    check("R6 no stall", st, 0);
    cpu_op(1'b0, 32'h038, '0, rd, st);
    check("R6 read back", rd, 32'hDEAD_0001);
    check("R6 no traffic", ev_n, 0);
    check("R6 memory stale", bmem[32'h038 >> 2], 32'hC000_0038);
  endtask

  task automatic t_dirty_evict();
    clear_log();
    cpu_op(1'b0, 32'h134, '0, rd, st);
    check("R7 data", rd, 32'hC000_0134);
    check("R7 events", ev_n, 8);
    check_ev("R7 wb0", 0, 1'b1, 32'h030, 32'hC000_0030);
    check_ev("R7 wb1", 1, 1'b1, 32'h034, 32'hC000_0034);
    check_ev("R7 wb2", 2, 1'b1, 32'h038, 32'hDEAD_0001);
    check_ev("R7 wb3", 3, 1'b1, 32'h03C, 32'hC000_003C);
    for (int i = 0; i < 4; i++) check_ev("R7 fill after", 4 + i, 1'b0, 32'h130 + 4 * i, '0);
  endtask

  task automatic t_wt_store();
    wb_mode = 1'b0; wr_alloc = 1'b1;
    cpu_op(1'b0, 32'h054, '0, rd, st);
    clear_log();
    cpu_op(1'b1, 32'h058, 32'hBEEF_0002, rd, st);
    check("R8 one access", ev_n, 1);
    check_ev("R8 write", 0, 1'b1, 32'h058, 32'hBEEF_0002);
    cpu_op(1'b0, 32'h058, '0, rd, st);
    check("R8 cached hit", st, 0);
    check("R8 cached word", rd, 32'hBEEF_0002);
    clear_log();
    cpu_op(1'b0, 32'h154, '0, rd, st);
    check("R8 line clean", n_writes(), 0);
  endtask

  task automatic t_no_alloc();
    wb_mode = 1'b0; wr_alloc = 1'b0;
    clear_log();
    cpu_op(1'b1, 32'h068, 32'h1234_5678, rd, st);
    check("R10 one access", ev_n, 1);
    check_ev("R10 write", 0, 1'b1, 32'h068, 32'h1234_5678);
    clear_log();
    cpu_op(1'b0, 32'h068, '0, rd, st);
    check("R10 still miss", ev_n, 4);
    check("R10 data", rd, 32'h1234_5678);
  endtask

  task automatic t_wr_alloc();
    wb_mode = 1'b1; wr_alloc = 1'b1;
    clear_log();
    cpu_op(1'b1, 32'h078, 32'hA1A1_A1A1, rd, st);
    check("R9 fill reads", ev_n, 4);
    check("R9 no write", n_writes(), 0);
    cpu_op(1'b0, 32'h078, '0, rd, st);
    check("R9 hit", st, 0);
    check("R9 word", rd, 32'hA1A1_A1A1);
    cpu_op(1'b0, 32'h074, '0, rd, st);
    check("R9 neighbour", rd, 32'hC000_0074);
  endtask

  task automatic t_flush();
    cpu_op(1'b0, 32'h020, '0, rd, st);
    cpu_op(1'b1, 32'h024, 32'h0000_F00D, rd, st);
    clear_log();
    dc = done_cnt;
    run_flush();
    check("R11 events", ev_n, 8);
    check_ev("R11 w0", 0, 1'b1, 32'h020, 32'hC000_0020);
    check_ev("R11 w1", 1, 1'b1, 32'h024, 32'h0000_F00D);
    check_ev("R11 w2", 2, 1'b1, 32'h028, 32'hC000_0028);
    check_ev("R11 w3", 3, 1'b1, 32'h02C, 32'hC000_002C);
    check_ev("R11 w4", 4, 1'b1, 32'h070, 32'hC000_0070);
    check_ev("R11 w6", 6, 1'b1, 32'h078, 32'hA1A1_A1A1);
    check_ev("R11 w7", 7, 1'b1, 32'h07C, 32'hC000_007C);
    check("R11 done pulse", done_cnt - dc, 1);
    clear_log();
    dc = done_cnt;
    run_flush();
    check("R11 second flush", ev_n, 0);
    check("R11 second done", done_cnt - dc, 1);
    cpu_op(1'b0, 32'h124, '0, rd, st);
    check("R11 cleared dirty", n_writes(), 0);
    check("R11 data", rd, 32'hC000_0124);
  endtask

  task automatic t_saturate();
    check("R12 hit sat", 32'(hit_count), 32'd7);
    check("R12 miss sat", 32'(miss_count), 32'd7);
    check("R13 hold", hold_viol, 0);
  endtask

  task automatic t_reset_invalid();
    do_reset();
    clear_log();
    cpu_op(1'b0, 32'h014, '0, rd, st);
    check("R2 miss after reset", ev_n, 4);
    check("R2 data", rd, 32'hC000_0014);
    check("R2 counts", 32'(miss_count), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_cold_fill();
    t_hit_offset();
    t_conflict();
    t_wb_store_hit();
    t_dirty_evict();
    t_wt_store();
    t_no_alloc();
    t_wr_alloc();
    t_flush();
    t_saturate();
    t_reset_invalid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule